// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt sources and presents them to a processor as two active-low level outputs: one for normal interrupts and one for fast interrupts. Software programs it through a simple single-cycle 32-bit register bus. Each source has an enable bit, a routing bit that sends it to the normal or the fast path, a 4-bit priority, and a force bit that makes it look asserted whatever its input does.

The normal path applies a programmable priority threshold. It publishes the number and priority of the most urgent pending normal source in a vector/status word, so a handler can dispatch without scanning. The fast path reports the highest-numbered pending fast source. Software turns single sources on and off by writing their number to dedicated registers, so no read-modify-write of the enable words is needed. Read data is combinational from the current address. Writes take effect at the rising clock edge.

Top module: `prio_intc`

## Requirements
- R1: After reset, control, enable, routing, force and priority state all read 0, the threshold register at 0x04 reads 0x1F, and both irqN and fiqN are high.
- R2: Writing a value n in 0..63 to 0x08 sets only the enable bit of source n. A value of 64 or more changes nothing.
- R3: Writing a value n in 0..63 to 0x0C clears only the enable bit of source n. All other enable bits keep their values.
- R4: The enable words (0x10 for sources 63..32, 0x14 for sources 31..0) and routing words (0x18 high, 0x1C low) are read/write, one bit per source. A routing bit of 1 selects the fast path.
- R5: Priority word g (sources 8g..8g+7) sits at offset 0x20 + 4*(7-g). Source s occupies bits [(s%8)*4+3:(s%8)*4].
- R6: A set bit in the force words (0x50 high, 0x54 low) makes that source count as asserted. The raw source words (0x48 high, 0x4C low) read the external inputs.
- R7: A source is requesting when (input OR force) AND enable. Requesting sources with routing 0 appear in the normal pending words (0x58 high, 0x5C low), and those with routing 1 appear in the fast pending words (0x60 high, 0x64 low).
- R8: With threshold m (5 bits) not equal to 0x1F, a normal source whose priority is at most m is masked. irqN is low exactly while some unmasked normal source is pending.
- R9: 0x40 reads {source number[31:16], priority[15:0]} of the highest-priority unmasked pending normal source. Ties go to the higher source number. It reads 0xFFFFFFFF when there is none.
- R10: fiqN is low exactly while some fast pending bit is set. 0x44 reads the highest-numbered pending fast source in bits [31:16] with zeros below, or 0xFFFFFFFF when there is none.
- R11: Writes to 0x40..0x4C and 0x58..0x64 change nothing. Reads of 0x08, 0x0C, offsets above 0x64 and addresses with nonzero byte bits [1:0] return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWr | input | 1 | Write strobe for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| srcIn | input | 64 | Level interrupt inputs, one per source |
| irqN | output | 1 | Normal interrupt request, active low |
| fiqN | output | 1 | Fast interrupt request, active low |

## Verification
The hardest situation to reach is a priority tie between unmasked normal sources while other sources at the same level are masked or routed to the fast path. Only then does the ordering rule of the vector become visible. The directed part of the bench builds such a tie on purpose: two normal sources with equal priority, one forced high-priority source in the upper word, and a fast source alongside. It then sweeps the threshold across the boundary values. After that, a long phase of random register writes and random input changes is compared cycle by cycle against a behavioural model. This exposes tie, threshold and routing combinations that no directed case names.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  localparam int GRP_W = 3;

  // write strobes plus word-select fields from the decoder
  typedef struct packed {
    logic             ctrlWr;
    logic             maskWr;
    logic             enNumWr;
    logic             disNumWr;
    logic             enWr;
    logic             typeWr;
    logic             forceWr;
    logic             prioWr;
    logic             hi;
    logic [GRP_W-1:0] grp;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RD_NONE, RD_CTRL, RD_MASK, RD_EN, RD_TYPE, RD_PRIO, RD_NVEC,
    RD_FVEC, RD_SRC, RD_FORCE, RD_NPEND, RD_FPEND
  } rdSel_t;

endpackage

// File: rtl/prio_intc_ctl.sv
module prio_intc_ctl
  import prio_intc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output wrStrobe_t         stb,
  output rdSel_t            rdSel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;

  assign idx     = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    stb     = '0;
    rdSel   = RD_NONE;
    stb.hi  = ~idx[0];          // even word of each pair is the upper half
    stb.grp = ~idx[GRP_W-1:0];  // priority words are stored in reverse group order
    if (aligned) begin
      case (idx)
        IDX_W'(0):  begin rdSel = RD_CTRL; stb.ctrlWr = busWr; end
        IDX_W'(1):  begin rdSel = RD_MASK; stb.maskWr = busWr; end
        IDX_W'(2):  stb.enNumWr  = busWr;
        IDX_W'(3):  stb.disNumWr = busWr;
        IDX_W'(4), IDX_W'(5): begin rdSel = RD_EN;   stb.enWr   = busWr; end
        IDX_W'(6), IDX_W'(7): begin rdSel = RD_TYPE; stb.typeWr = busWr; end
        IDX_W'(8),  IDX_W'(9),  IDX_W'(10), IDX_W'(11),
        IDX_W'(12), IDX_W'(13), IDX_W'(14), IDX_W'(15):
                    begin rdSel = RD_PRIO; stb.prioWr = busWr; end
        IDX_W'(16): rdSel = RD_NVEC;
        IDX_W'(17): rdSel = RD_FVEC;
        IDX_W'(18), IDX_W'(19): rdSel = RD_SRC;
        IDX_W'(20), IDX_W'(21): begin rdSel = RD_FORCE; stb.forceWr = busWr; end
        IDX_W'(22), IDX_W'(23): rdSel = RD_NPEND;
        IDX_W'(24), IDX_W'(25): rdSel = RD_FPEND;
        default: rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  rdSel_t            rdSel,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NSRC-1:0]   srcIn,
  output logic              irqN,
  output logic              fiqN
);
  localparam int HALF     = NSRC / 2;
  localparam int NUM_W    = $clog2(NSRC);
  localparam int MASK_W   = PRIO_W + 1;
  localparam int PER_WORD = DATA_W / PRIO_W;
  localparam int HW       = DATA_W / 2;

  logic [DATA_W-1:0]            ctrlReg;
  logic [MASK_W-1:0]            maskReg;
  logic [NSRC-1:0]              enReg, typeReg, forceReg;
  logic [NSRC-1:0][PRIO_W-1:0]  prioReg;

  logic              numOk;
  logic [NUM_W-1:0]  num;
  assign numOk = (busWdata[DATA_W-1:NUM_W] == '0);
  assign num   = busWdata[NUM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      maskReg  <= '1;
      enReg    <= '0;
      typeReg  <= '0;
      forceReg <= '0;
      prioReg  <= '0;
    end else begin
      if (stb.ctrlWr)            ctrlReg <= busWdata;
      if (stb.maskWr)            maskReg <= busWdata[MASK_W-1:0];
      if (stb.enNumWr && numOk)  enReg[num] <= 1'b1;
      if (stb.disNumWr && numOk) enReg[num] <= 1'b0;
      if (stb.enWr) begin
        if (stb.hi) enReg[NSRC-1:HALF] <= busWdata;
        else        enReg[HALF-1:0]    <= busWdata;
      end
      if (stb.typeWr) begin
        if (stb.hi) typeReg[NSRC-1:HALF] <= busWdata;
        else        typeReg[HALF-1:0]    <= busWdata;
      end
      if (stb.forceWr) begin
        if (stb.hi) forceReg[NSRC-1:HALF] <= busWdata;
        else        forceReg[HALF-1:0]    <= busWdata;
      end
      if (stb.prioWr) begin
        for (int k = 0; k < PER_WORD; k++)
          prioReg[int'(stb.grp)*PER_WORD + k] <= busWdata[k*PRIO_W +: PRIO_W];
      end
    end
  end

  // request, routing and threshold
  logic [NSRC-1:0] req, nPend, fPend, unmasked, nLive;
  assign req   = (srcIn | forceReg) & enReg;
  assign nPend = req & ~typeReg;
  assign fPend = req & typeReg;

  for (genvar s = 0; s < NSRC; s++) begin : g_thr
    assign unmasked[s] = (maskReg == '1) || ({1'b0, prioReg[s]} > maskReg);
  end
  assign nLive = nPend & unmasked;

  // normal arbiter: ascending scan, >= lets higher numbers win ties
  logic              nFound, fFound;
  logic [NUM_W-1:0]  nBestNum, fNum;
  logic [PRIO_W-1:0] nBestPri;
  always_comb begin
    nFound   = 1'b0;
    nBestNum = '0;
    nBestPri = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (nLive[s] && (!nFound || prioReg[s] >= nBestPri)) begin
        nFound   = 1'b1;
        nBestNum = NUM_W'(s);
        nBestPri = prioReg[s];
      end
    end
  end

  always_comb begin
    fFound = 1'b0;
    fNum   = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (fPend[s]) begin
        fFound = 1'b1;
        fNum   = NUM_W'(s);
      end
    end
  end

  logic [DATA_W-1:0] nVec, fVec, prioWord;
  assign nVec = nFound ? {HW'(nBestNum), HW'(nBestPri)} : '1;
  assign fVec = fFound ? {HW'(fNum), HW'(0)} : '1;

  always_comb begin
    for (int k = 0; k < PER_WORD; k++)
      prioWord[k*PRIO_W +: PRIO_W] = prioReg[int'(stb.grp)*PER_WORD + k];
  end

  assign irqN = ~|nLive;
  assign fiqN = ~|fPend;

  always_comb begin
    case (rdSel)
      RD_CTRL:  busRdata = ctrlReg;
      RD_MASK:  busRdata = DATA_W'(maskReg);
      RD_EN:    busRdata = stb.hi ? enReg[NSRC-1:HALF]    : enReg[HALF-1:0];
      RD_TYPE:  busRdata = stb.hi ? typeReg[NSRC-1:HALF]  : typeReg[HALF-1:0];
      RD_PRIO:  busRdata = prioWord;
      RD_NVEC:  busRdata = nVec;
      RD_FVEC:  busRdata = fVec;
      RD_SRC:   busRdata = stb.hi ? srcIn[NSRC-1:HALF]    : srcIn[HALF-1:0];
      RD_FORCE: busRdata = stb.hi ? forceReg[NSRC-1:HALF] : forceReg[HALF-1:0];
      RD_NPEND: busRdata = stb.hi ? nPend[NSRC-1:HALF]    : nPend[HALF-1:0];
      RD_FPEND: busRdata = stb.hi ? fPend[NSRC-1:HALF]    : fPend[HALF-1:0];
      default:  busRdata = '0;
    endcase
  end

  AST_ENNUM_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.enNumWr |=> $countones(enReg ^ $past(enReg)) <= 1); // R2
  AST_DISNUM_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.disNumWr |=> $countones(enReg ^ $past(enReg)) <= 1); // R3
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.enWr || stb.enNumWr || stb.disNumWr) |=> $stable(enReg)); // R4
  AST_IRQ_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> (maskReg == '1 || MASK_W'(nVec[PRIO_W-1:0]) > maskReg)); // R8
  AST_IRQ_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rstN)
    irqN == (nVec == '1)); // R9
  AST_FIQ_ROUTED: assert property (@(posedge clk) disable iff (!rstN)
    !fiqN |-> |(typeReg & enReg)); // R10

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NSRC   = 64,
  parameter int DATA_W = 32,
  parameter int PRIO_W = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NSRC-1:0]   srcIn,
  output logic              irqN,
  output logic              fiqN
);
  wrStrobe_t stb;
  rdSel_t    rdSel;

  prio_intc_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .stb     (stb),
    .rdSel   (rdSel)
  );

  prio_intc_dp #(.NSRC(NSRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .rdSel    (rdSel),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .srcIn    (srcIn),
    .irqN     (irqN),
    .fiqN     (fiqN)
  );

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [63:0] srcIn = '0;
  logic        irqN, fiqN;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  prio_intc uut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
                 .busWdata(busWdata), .busRdata(busRdata), .srcIn(srcIn),
                 .irqN(irqN), .fiqN(fiqN));

  // behavioural reference state
  logic [63:0] mEn = '0, mTyp = '0, mFrc = '0;
  int          mPri[64];
  logic [31:0] mCtrl = '0;
  int          mMask = 31;

  function automatic int bestNormal();
    int best = -1;
    int bp = -1;
    logic [63:0] r = (srcIn | mFrc) & mEn & ~mTyp;
    for (int s = 0; s < 64; s++)
      if (r[s] && (mMask == 31 || mPri[s] > mMask) && mPri[s] >= bp) begin
        best = s; bp = mPri[s];
      end
    return best;
  endfunction

  function automatic int bestFast();
    int best = -1;
    logic [63:0] r = (srcIn | mFrc) & mEn & mTyp;
    for (int s = 0; s < 64; s++) if (r[s]) best = s;
    return best;
  endfunction

  function automatic logic [31:0] modelRead(input logic [7:0] a);
    int w = int'(a) / 4;
    logic [63:0] req = (srcIn | mFrc) & mEn;
    logic [31:0] r = '0;
    int b;
    if (a[1:0] != 2'b00) return '0;
    if (w == 0) r = mCtrl;
    else if (w == 1) r = 32'(mMask);
    else if (w == 4) r = mEn[63:32];
    else if (w == 5) r = mEn[31:0];
    else if (w == 6) r = mTyp[63:32];
    else if (w == 7) r = mTyp[31:0];
    else if (w >= 8 && w <= 15) begin
      for (int k = 0; k < 8; k++) r[k*4 +: 4] = 4'(mPri[(15 - w) * 8 + k]);
    end else if (w == 16) begin
      b = bestNormal();
      r = (b < 0) ? 32'hFFFF_FFFF : {16'(b), 16'(mPri[b])};
    end else if (w == 17) begin
      b = bestFast();
      r = (b < 0) ? 32'hFFFF_FFFF : {16'(b), 16'h0};
    end
    else if (w == 18) r = srcIn[63:32];
    else if (w == 19) r = srcIn[31:0];
    else if (w == 20) r = mFrc[63:32];
    else if (w == 21) r = mFrc[31:0];
    else if (w == 22) r = (req & ~mTyp) >> 32;
    else if (w == 23) r = 32'(req & ~mTyp);
    else if (w == 24) r = (req & mTyp) >> 32;
    else if (w == 25) r = 32'(req & mTyp);
    return r;
  endfunction

  function automatic string tagOf(input logic [7:0] a);
    int w = int'(a) / 4;
    if (w <= 1) return "R1";
    if (w == 2) return "R2";
    if (w == 3) return "R3";
    if (w <= 7) return "R4";
    if (w <= 15) return "R5";
    if (w == 16) return "R9";
    if (w == 17) return "R10";
    if (w <= 21) return "R6";
    if (w <= 25) return "R7";
    return "R11";
  endfunction

  task automatic modelWrite(input logic [7:0] a, input logic [31:0] d);
    int w = int'(a) / 4;
    if (a[1:0] != 2'b00) return;
    if (w == 0) mCtrl = d;
    else if (w == 1) mMask = int'(d[4:0]);
    else if (w == 2) begin if (d < 64) mEn[d[5:0]] = 1'b1; end
    else if (w == 3) begin if (d < 64) mEn[d[5:0]] = 1'b0; end
    else if (w == 4) mEn[63:32] = d;
    else if (w == 5) mEn[31:0] = d;
    else if (w == 6) mTyp[63:32] = d;
    else if (w == 7) mTyp[31:0] = d;
    else if (w >= 8 && w <= 15) begin
      for (int k = 0; k < 8; k++) mPri[(15 - w) * 8 + k] = int'(d[k*4 +: 4]);
    end
    else if (w == 20) mFrc[63:32] = d;
    else if (w == 21) mFrc[31:0] = d;
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // tasks start and end on a falling edge
  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk);
    #1 modelWrite(a, d);
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, input logic [31:0] exp, input string tag);
    busAddr = a; busWr = 1'b0;
    #5 check(tag, busRdata, exp);
    @(negedge clk);
  endtask

  task automatic setSrc(input logic [63:0] v);
    srcIn = v;
    #5;
    @(negedge clk);
  endtask

  // cycle-by-cycle comparison against the model
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (rstN && !done) begin
        check("R8", 32'(irqN), 32'(bestNormal() < 0));
        check("R10", 32'(fiqN), 32'(bestFast() < 0));
        check(tagOf(busAddr), busRdata, modelRead(busAddr));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) mPri[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(8'h04, 32'h1F, "R1");
    busRead(8'h00, 32'h0, "R1");
    busRead(8'h14, 32'h0, "R1");
    busRead(8'h20, 32'h0, "R1");
    busRead(8'h40, 32'hFFFF_FFFF, "R1");
    check("R1", {30'h0, irqN, fiqN}, 32'h3);

    // R2 enable by number
    busWrite(8'h08, 32'd5);
    busWrite(8'h08, 32'd40);
    busRead(8'h14, 32'h20, "R2");
    busRead(8'h10, 32'h100, "R2");
    busWrite(8'h08, 32'd70);
    busRead(8'h10, 32'h100, "R2");
    busRead(8'h14, 32'h20, "R2");
    // R3 disable by number
    busWrite(8'h0C, 32'd5);
    busRead(8'h14, 32'h0, "R3");
    busRead(8'h10, 32'h100, "R3");

    // R4 enable and routing words
    busWrite(8'h14, 32'hF);
    busRead(8'h14, 32'hF, "R4");
    busWrite(8'h1C, 32'h8);
    busRead(8'h1C, 32'h8, "R4");
    busRead(8'h18, 32'h0, "R4");

    // R5 reversed priority words
    busWrite(8'h28, 32'h9);       // group 5: source 40 gets 9
    busWrite(8'h3C, 32'h5505);    // group 0: sources 0,2,3 get 5
    busRead(8'h28, 32'h9, "R5");
    busRead(8'h3C, 32'h5505, "R5");

    // R7 / R9 tie between sources 0 and 2
    setSrc(64'h0);
    busRead(8'h40, 32'hFFFF_FFFF, "R9");
    setSrc(64'h5);
    busRead(8'h5C, 32'h5, "R7");
    busRead(8'h40, 32'h0002_0005, "R9");
    check("R8", 32'(irqN), 32'h0);

    // R6 force on source 40
    busWrite(8'h50, 32'h100);
    busRead(8'h40, 32'h0028_0009, "R6");
    busRead(8'h58, 32'h100, "R7");
    busRead(8'h48, 32'h0, "R6");

    // R8 threshold sweep
    busWrite(8'h04, 32'd8);
    busRead(8'h40, 32'h0028_0009, "R8");
    busWrite(8'h04, 32'd9);
    busRead(8'h40, 32'hFFFF_FFFF, "R8");
    check("R8", 32'(irqN), 32'h1);
    busWrite(8'h04, 32'd4);
    busRead(8'h40, 32'h0028_0009, "R8");
    busWrite(8'h04, 32'h1F);

    // R10 fast path
    busWrite(8'h1C, 32'hA);
    setSrc(64'hF);
    busRead(8'h64, 32'hA, "R10");
    busRead(8'h44, 32'h0003_0000, "R10");
    check("R10", 32'(fiqN), 32'h0);
    busRead(8'h5C, 32'h5, "R7");

    // R11 read-only, unmapped, unaligned
    busWrite(8'h5C, 32'hFFFF_FFFF);
    busRead(8'h5C, 32'h5, "R11");
    busWrite(8'h40, 32'h0);
    busRead(8'h40, 32'h0028_0009, "R11");
    busWrite(8'h48, 32'hFFFF_FFFF);
    busRead(8'h48, 32'h0, "R11");
    busRead(8'h68, 32'h0, "R11");
    busRead(8'h05, 32'h0, "R11");
    busWrite(8'h15, 32'h0);
    busRead(8'h14, 32'hF, "R11");
    // R7 force on a disabled source stays out of pending
    busWrite(8'h54, 32'h10);
    busRead(8'h5C, 32'h5, "R7");

    // random phase, checked every cycle by the monitor
    for (int n = 0; n < 4000; n++) begin
      int w;
      logic [31:0] d;
      w = $urandom_range(0, 31);
      d = $urandom();
      if (w == 2 || w == 3) d = $urandom_range(0, 70);
      if (w == 1) d = $urandom_range(0, 31);
      if (($urandom() & 3) == 0) srcIn = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      if ($urandom() & 1) busWrite(8'(w * 4), d);
      else begin
        busAddr = 8'(w * 4);
        @(negedge clk);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule